// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Interrupts

This block is a 32-pin general-purpose I/O port controlled through a plain 32-bit register bus: a byte address, a write strobe, write data and a combinational read-data return. Each register holds one bit per pin. Software sets the driven level, chooses per pin whether it drives or listens, can make a driven pin blink, and can invert how each input is seen.

Pad inputs pass through a two-flop synchronizer and are then XORed with the inversion register. The result is both the data-in value software reads and the source for the interrupt logic. A rising transition of that adjusted value latches a bit in the pending-edge register. The single interrupt output combines edge-masked pending bits with level-masked live inputs. Pad buffers are represented by a value vector and an active-high drive vector; the surrounding pad ring builds the tri-state buffer.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is an input (`pad_en_o` all zero), the direction register reads 0xFFFFFFFF, every other register reads zero and `irq_o` is low.
- R2: Registers sit at byte offsets 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C input inversion, 0x10 data-in (read-only: writes are ignored), 0x14 pending edges, 0x18 edge mask and 0x1C level mask. Any other address reads zero.
- R3: The direction register is active-low: a pin whose bit is 0 drives (`pad_en_o` bit is 1) and a pin whose bit is 1 is an input. A driven, non-blinking pin shows its output-value bit on `pad_o`.
- R4: Data-in equals the pad value XOR the inversion bit. A pad change made before clock edge k is readable after edge k+1 and not before.
- R5: A rising transition of the adjusted data-in sets that pin's pending bit one clock later, so a pad change before edge k is pending after edge k+2. With inversion set, a falling pad produces the transition.
- R6: A write to the pending register clears each bit written as 0 and keeps each bit written as 1; writing all zeros clears every pending bit. Without a write or a new edge, pending bits hold.
- R7: When a new edge and a pending-register write fall in the same cycle, the edge's bit ends up set even though 0 was written to it.
- R8: `irq_o` is the OR over all pins of (pending AND edge mask) OR (data-in AND level mask). It follows the live input for level-masked pins and ignores pending bits whose edge mask is zero.
- R9: A pin with its blink bit set drives a square wave on `pad_o` that changes every BLINK_HALF clock cycles in place of its output-value bit; pins without blink keep their output-value bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | NUM_PINS | Write data |
| rdata_o | output | NUM_PINS | Read data for `addr_i`, combinational |
| pad_i | input | NUM_PINS | Raw pad input levels |
| pad_o | output | NUM_PINS | Level presented to each pad driver |
| pad_en_o | output | NUM_PINS | Drive enable per pad, active high |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The pending-edge register can be set by a new input edge and cleared by a software write in the same cycle. The bench raises a pad, waits the two synchronizer edges so the rising transition is present, and holds a write of all zeros to the pending register across exactly the clock edge that latches that transition. The result is judged from the read-back: the older pending bit must be gone and the new edge's bit must remain.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Register index = byte offset / 4; software decodes this order.
  typedef enum logic [2:0] {
    SEL_DOUT  = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_POL   = 3'd3,
    SEL_DIN   = 3'd4,
    SEL_CAUSE = 3'd5,
    SEL_EMASK = 3'd6,
    SEL_LMASK = 3'd7
  } reg_sel_e;

  localparam int unsigned SEL_W  = 3;
  localparam int unsigned BYTE_W = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] d_i,
  output logic [NUM_PINS-1:0] q_o
);
  logic [NUM_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] din_i,
  input  logic [NUM_PINS-1:0] cause_i,
  output logic [NUM_PINS-1:0] dout_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] blink_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] emask_o,
  output logic [NUM_PINS-1:0] lmask_o,
  output logic                cause_wr_o,
  output logic [NUM_PINS-1:0] rdata_o
);
  localparam int unsigned TOP_LSB = SEL_W + BYTE_W;

  logic     hit;
  logic     upper_zero;
  reg_sel_e sel;

  if (ADDR_W > TOP_LSB) begin : g_upper
    assign upper_zero = (addr_i[ADDR_W-1:TOP_LSB] == '0);
  end else begin : g_noupper
    assign upper_zero = 1'b1;
  end

  assign sel = reg_sel_e'(addr_i[TOP_LSB-1:BYTE_W]);
  assign hit = upper_zero && (addr_i[BYTE_W-1:0] == '0);

  logic wr_hit;
  assign wr_hit     = wr_en_i && hit;
  assign cause_wr_o = wr_hit && (sel == SEL_CAUSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o  <= '0;
      dir_o   <= '1;
      blink_o <= '0;
      pol_o   <= '0;
      emask_o <= '0;
      lmask_o <= '0;
    end else if (wr_hit) begin
      unique case (sel)
        SEL_DOUT:  dout_o  <= wdata_i;
        SEL_DIR:   dir_o   <= wdata_i;
        SEL_BLINK: blink_o <= wdata_i;
        SEL_POL:   pol_o   <= wdata_i;
        SEL_EMASK: emask_o <= wdata_i;
        SEL_LMASK: lmask_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (sel)
        SEL_DOUT:  rdata_o = dout_o;
        SEL_DIR:   rdata_o = dir_o;
        SEL_BLINK: rdata_o = blink_o;
        SEL_POL:   rdata_o = pol_o;
        SEL_DIN:   rdata_o = din_i;
        SEL_CAUSE: rdata_o = cause_i;
        SEL_EMASK: rdata_o = emask_o;
        SEL_LMASK: rdata_o = lmask_o;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned BLINK_HALF = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] dout_i,
  input  logic [NUM_PINS-1:0] blink_i,
  output logic [NUM_PINS-1:0] pad_o
);
  localparam int unsigned CNT_W = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pad_o[p] = blink_i[p] ? phase_q : dout_i[p];
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] din_i,
  input  logic [NUM_PINS-1:0] emask_i,
  input  logic [NUM_PINS-1:0] lmask_i,
  input  logic                cause_wr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] cause_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] kept;

  assign rise_o = din_i & ~prev_q;
  // Written zeros clear, written ones keep; a new edge overrides the clear.
  assign kept   = cause_wr_i ? (cause_o & wdata_i) : cause_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      cause_o <= '0;
    end else begin
      prev_q  <= din_i;
      cause_o <= kept | rise_o;
    end
  end

  assign irq_o = |((cause_o & emask_i) | (din_i & lmask_i));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS   = 32,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned BLINK_HALF = 1024,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_en_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] dout, dir, blink, pol, emask, lmask;
  logic [NUM_PINS-1:0] pad_s, din, rise, cause;
  logic                cause_wr;

  gpio_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_s)
  );

  assign din = pad_s ^ pol;

  gpio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wdata_i   (wdata_i),
    .din_i     (din),
    .cause_i   (cause),
    .dout_o    (dout),
    .dir_o     (dir),
    .blink_o   (blink),
    .pol_o     (pol),
    .emask_o   (emask),
    .lmask_o   (lmask),
    .cause_wr_o(cause_wr),
    .rdata_o   (rdata_o)
  );

  gpio_blink #(.NUM_PINS(NUM_PINS), .BLINK_HALF(BLINK_HALF)) u_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dout_i (dout),
    .blink_i(blink),
    .pad_o  (pad_o)
  );

  gpio_irq #(.NUM_PINS(NUM_PINS)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .din_i     (din),
    .emask_i   (emask),
    .lmask_i   (lmask),
    .cause_wr_i(cause_wr),
    .wdata_i   (wdata_i),
    .rise_o    (rise),
    .cause_o   (cause),
    .irq_o     (irq_o)
  );

  // Direction register is active-low; the pad enable is active-high.
  assign pad_en_o = ~dir;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] din_i,
  input logic [NUM_PINS-1:0] rise_i,
  input logic [NUM_PINS-1:0] cause_i,
  input logic [NUM_PINS-1:0] emask_i,
  input logic [NUM_PINS-1:0] lmask_i,
  input logic                cause_wr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic                irq_i
);
  p_rise_sets_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((cause_i & $past(rise_i)) == $past(rise_i)));

  p_edge_beats_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_wr_i && (wdata_i == '0)) |=> (cause_i == $past(rise_i)));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_wr_i && (rise_i == '0)) |=> (cause_i == ($past(cause_i) & $past(wdata_i))));

  p_cause_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cause_wr_i && (rise_i == '0)) |=> $stable(cause_i));

  p_irq_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((emask_i == '0) && (lmask_i == '0)) |-> !irq_i);

  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((din_i & lmask_i) != '0) |-> irq_i);

  p_irq_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_i & emask_i) != '0) |-> irq_i);
endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .din_i     (din),
  .rise_i    (rise),
  .cause_i   (cause),
  .emask_i   (emask),
  .lmask_i   (lmask),
  .cause_wr_i(cause_wr),
  .wdata_i   (wdata_i),
  .irq_i     (irq_o)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int unsigned NP       = 32;
  localparam int unsigned AW       = 6;
  localparam int unsigned HALF     = 8;
  localparam time         CLK_PER  = 10ns;

  localparam logic [AW-1:0] A_DOUT  = 6'h00;
  localparam logic [AW-1:0] A_DIR   = 6'h04;
  localparam logic [AW-1:0] A_BLINK = 6'h08;
  localparam logic [AW-1:0] A_POL   = 6'h0C;
  localparam logic [AW-1:0] A_DIN   = 6'h10;
  localparam logic [AW-1:0] A_CAUSE = 6'h14;
  localparam logic [AW-1:0] A_EMASK = 6'h18;
  localparam logic [AW-1:0] A_LMASK = 6'h1C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wen = 1'b0;
  logic [NP-1:0] wdata = '0;
  logic [NP-1:0] rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_en;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  gpio_port #(.NUM_PINS(NP), .ADDR_W(AW), .BLINK_HALF(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wen), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out), .pad_en_o(pad_en), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wen = 1'b0; pad_in = '0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NP-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [NP-1:0] v;
    do_reset();
    chk("R1 pad_en", pad_en, '0);
    chk("R1 irq", NP'(irq), '0);
    rd(A_DIR, v);   chk("R1 dir", v, '1);
    rd(A_DOUT, v);  chk("R1 dout", v, '0);
    rd(A_EMASK, v); chk("R1 emask", v, '0);
    rd(A_LMASK, v); chk("R1 lmask", v, '0);
    rd(A_CAUSE, v); chk("R1 cause", v, '0);
  endtask

  task automatic t_regs();
    logic [NP-1:0] v;
    do_reset();
    wr(A_DOUT, 32'h1234_5678);
    rd(A_DOUT, v);  chk("R2 dout rb", v, 32'h1234_5678);
    wr(A_EMASK, 32'h0F0F_0000);
    rd(A_EMASK, v); chk("R2 emask rb", v, 32'h0F0F_0000);
    wr(A_LMASK, 32'h0000_A000);
    rd(A_LMASK, v); chk("R2 lmask rb", v, 32'h0000_A000);
    wr(A_BLINK, 32'h8000_0001);
    rd(A_BLINK, v); chk("R2 blink rb", v, 32'h8000_0001);
    wr(A_DIN, '1);
    rd(A_DIN, v);   chk("R2 din write ignored", v, '0);
    rd(6'h20, v);   chk("R2 unmapped", v, '0);
  endtask

  task automatic t_drive();
    do_reset();
    wr(A_DOUT, 32'hF0F0_00FF);
    wr(A_DIR, 32'hFFFF_0000);
    chk("R3 pad_en", pad_en, 32'h0000_FFFF);
    chk("R3 pad_o", pad_out, 32'hF0F0_00FF);
    wr(A_DIR, '1);
    chk("R3 all input", pad_en, '0);
  endtask

  task automatic t_din();
    logic [NP-1:0] v;
    do_reset();
    pad_in = 32'h0000_00C3;
    wait_n(1);
    rd(A_DIN, v); chk("R4 din early", v, '0);
    wait_n(1);
    rd(A_DIN, v); chk("R4 din synced", v, 32'h0000_00C3);
    wr(A_POL, 32'h0000_0003);
    rd(A_DIN, v); chk("R4 din inverted", v, 32'h0000_00C0);
  endtask

  task automatic t_edge_ack();
    logic [NP-1:0] v;
    do_reset();
    pad_in[4] = 1'b1;
    wait_n(2);
    rd(A_CAUSE, v); chk("R5 cause not yet", v, '0);
    wait_n(1);
    rd(A_CAUSE, v); chk("R5 cause rise", v, 32'h10);
    pad_in[9] = 1'b1;
    wait_n(3);
    wr(A_CAUSE, 32'hFFFF_FDFF);
    wr(A_POL, 32'h200);
    pad_in[9] = 1'b0;
    wait_n(3);
    rd(A_CAUSE, v); chk("R5 inverted fall", v, 32'h210);
    wr(A_CAUSE, 32'hFFFF_FDFF);
    rd(A_CAUSE, v); chk("R6 selective ack", v, 32'h10);
    wait_n(4);
    rd(A_CAUSE, v); chk("R6 hold", v, 32'h10);
    wr(A_CAUSE, '0);
    rd(A_CAUSE, v); chk("R6 clear all", v, '0);
  endtask

  task automatic t_race();
    logic [NP-1:0] v;
    do_reset();
    pad_in[0] = 1'b1;
    wait_n(3);
    rd(A_CAUSE, v); chk("R7 setup", v, 32'h1);
    pad_in[5] = 1'b1;
    wait_n(2);
    addr = A_CAUSE; wdata = '0; wen = 1'b1;
    wait_n(1);
    wen = 1'b0;
    rd(A_CAUSE, v); chk("R7 edge beats clear", v, 32'h20);
  endtask

  task automatic t_irq();
    do_reset();
    wr(A_EMASK, 32'h4);
    pad_in[2] = 1'b1;
    wait_n(3);
    chk("R8 edge irq", NP'(irq), 1);
    wr(A_CAUSE, '0);
    chk("R8 edge acked", NP'(irq), 0);
    wr(A_LMASK, 32'h80);
    pad_in[7] = 1'b1;
    wait_n(1);
    chk("R8 level early", NP'(irq), 0);
    wait_n(1);
    chk("R8 level high", NP'(irq), 1);
    pad_in[7] = 1'b0;
    wait_n(2);
    chk("R8 level gone, unmasked cause", NP'(irq), 0);
    wr(A_POL, 32'h80);
    chk("R8 level via inversion", NP'(irq), 1);
  endtask

  task automatic t_blink();
    logic prev;
    int   gap;
    do_reset();
    wr(A_DOUT, 32'h4);
    wr(A_DIR, ~32'hC);
    wr(A_BLINK, 32'h8);
    prev = pad_out[3];
    for (int i = 0; i < 3*HALF && pad_out[3] == prev; i++) wait_n(1);
    prev = pad_out[3];
    gap = 0;
    for (int i = 0; i < 3*HALF && pad_out[3] == prev; i++) begin
      wait_n(1);
      gap++;
    end
    chk("R9 half period", NP'(gap), NP'(HALF));
    chk("R9 steady pin", NP'(pad_out[2]), 1);
    wr(A_BLINK, '0);
    chk("R9 blink off", NP'(pad_out[3]), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_drive();
    t_din();
    t_edge_ack();
    t_race();
    t_irq();
    t_blink();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule